// File: doc/BRIEF.md
# Video Mode Bank Register File

This block is the software-facing register set of a video output engine. A host reaches it through a plain word-addressed port (address, write data, write strobe, read strobe, read data). Five registers hold run control, live status, latched interrupt flags, the identity of the active video mode, and a pointer that selects one of several stored mode banks.

Each bank holds 25 timing words and a valid flag. The host writes these words indirectly: it sets the bank pointer and then writes the per-mode addresses, which cannot be read back. A mode index input from the engine chooses among the banks. The lowest valid bank whose standard word equals that index becomes active. Its words drive a wide parameter output. While no bank matches, the output carries all-zero defaults.

The interrupt line is the registered OR of the latched flags, each gated by its enable bit. A build option removes the interrupt entirely.

Top module: `vmode_regs`

## Requirements
- R1: After reset, the control, status-flag, interrupt-flag, bank-pointer and match registers all read 0. `go_o`, `sync_en_o`, `lock_en_o` and `irq_o` are low, and `mode_params_o` is all zero.
- R2: Address 0 is control. Bit 0 drives `go_o` and bit 3 drives `sync_en_o`. `lock_en_o` is bit 4 ANDed with bit 3. Bits 8 and 9 are the interrupt enables. A read returns bits 0, 3, 4, 8 and 9 as written, and all other bits as 0.
- R3: Address 1 is status. Bit 0 follows `vid_active_i`, bit 1 reads 0, bit 2 is the sticky underflow flag, and bit 3 is `locked_i` registered once.
- R4: The underflow flag sets on any cycle with `underflow_i` high. It stays set until a control write carries 1 in bit 2. If the event and the clear happen in the same cycle, the flag stays set.
- R5: Address 2 holds two flags. Bit 8 sets when the match register changes value, and bit 9 sets on a rising edge of the registered lock input. Writing 1 to a bit clears only that flag. A new event in the same cycle keeps the flag set.
- R6: One cycle after the flags and enables give a nonzero AND, `irq_o` is high. It is low otherwise. With `HAS_CTRL` = 0, `irq_o` is always 0.
- R7: Address 3 reads 0 while no bank matches. Otherwise it reads a one-hot value, with bit N set for bank N. Bank N matches when its valid flag is set and its standard word (address 22) equals `req_mode_i`. The lowest such bank wins. The register updates on the clock edge after the condition changes.
- R8: Address 4 is the bank pointer, in binary, and reads back. A write of a value at or above `NBANKS` is ignored.
- R9: A write to addresses 5 to 29 stores the low `PW` bits into word (address − 5) of the selected bank. A write to address 30 stores bit 0 as that bank's valid flag. Reads of addresses 5 to 30 return 0.
- R10: `mode_params_o[k*PW +: PW]` carries word k of the active bank. All bits are 0 while the match register is 0.
- R11: Read data is registered and appears the cycle after `rd_en`. Address 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| req_mode_i | input | PW | Mode index requested by the output engine |
| vid_active_i | input | 1 | Engine is producing video |
| underflow_i | input | 1 | FIFO underflow event pulse |
| locked_i | input | 1 | Frame alignment achieved |
| go_o | output | 1 | Start output |
| sync_en_o | output | 1 | Enable sync outputs |
| lock_en_o | output | 1 | Enable frame locking |
| irq_o | output | 1 | Interrupt request |
| mode_params_o | output | 25*PW | Timing words of the active bank |

## Verification
The hardest state to reach from the ports is two banks matching the same index at once. The bench must show that the lower bank takes over from a higher one that was already active. To get there it programs bank 2 first and confirms it is active. It then moves the pointer down, gives bank 1 the same standard word and sets its valid flag. The match must then move to bit 1, and the parameter output must switch to bank 1's words, which were never written and so are zero. Same-cycle races are also hard to reach: the bench drives an underflow pulse in the same cycle as a clear write, and expects the sticky flag to survive.

// File: rtl/vmode_regs.sv
module vmode_regs #(
  parameter int NBANKS   = 4,
  parameter int PW       = 16,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [4:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [PW-1:0]       req_mode_i,
  input  logic                vid_active_i,
  input  logic                underflow_i,
  input  logic                locked_i,
  output logic                go_o,
  output logic                sync_en_o,
  output logic                lock_en_o,
  output logic                irq_o,
  output logic [25*PW-1:0]    mode_params_o
);
  localparam int NPAR    = 25;
  localparam int STD_IDX = 17;
  localparam int BW      = (NBANKS > 1) ? $clog2(NBANKS) : 1;

  logic go_q, sync_q, lock_q, ie_upd, ie_lock;
  logic uf_q, locked_q, if_upd, if_lock, irq_q;
  logic [BW-1:0]     bank;
  logic [NBANKS-1:0] valid, match_q, match_nxt;
  logic [PW-1:0]     bank_mem [NBANKS][NPAR];
  logic [BW-1:0]     act_idx;

  wire wr_ctrl  = wr_en && addr == 5'd0;
  wire wr_irq   = wr_en && addr == 5'd2;
  wire wr_bank  = wr_en && addr == 5'd4;
  wire wr_par   = wr_en && addr >= 5'd5 && addr <= 5'd29;
  wire wr_valid = wr_en && addr == 5'd30;
  wire lock_rise = locked_i && !locked_q;

  assign go_o      = go_q;
  assign sync_en_o = sync_q;
  assign lock_en_o = sync_q && lock_q;
  assign irq_o     = irq_q;

  always_comb begin
    match_nxt = '0;
    for (int b = NBANKS - 1; b >= 0; b--)
      if (valid[b] && bank_mem[b][STD_IDX] == req_mode_i)
        match_nxt = NBANKS'(1) << b;
  end

  always_comb begin
    act_idx = '0;
    for (int b = 0; b < NBANKS; b++)
      if (match_q[b]) act_idx = BW'(b);
    for (int k = 0; k < NPAR; k++)
      mode_params_o[k*PW +: PW] = (|match_q) ? bank_mem[act_idx][k] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {go_q, sync_q, lock_q, ie_upd, ie_lock} <= '0;
      {uf_q, locked_q, if_upd, if_lock, irq_q} <= '0;
      bank    <= '0;
      valid   <= '0;
      match_q <= '0;
      rdata   <= '0;
      for (int b = 0; b < NBANKS; b++)
        for (int k = 0; k < NPAR; k++)
          bank_mem[b][k] <= '0;
    end else begin
      if (wr_ctrl) begin
        go_q    <= wdata[0];
        sync_q  <= wdata[3];
        lock_q  <= wdata[4];
        ie_upd  <= wdata[8];
        ie_lock <= wdata[9];
      end
      uf_q     <= underflow_i || (uf_q && !(wr_ctrl && wdata[2]));
      locked_q <= locked_i;
      if_upd   <= (match_nxt != match_q) || (if_upd && !(wr_irq && wdata[8]));
      if_lock  <= lock_rise || (if_lock && !(wr_irq && wdata[9]));
      irq_q    <= HAS_CTRL && ((if_upd && ie_upd) || (if_lock && ie_lock));
      match_q  <= match_nxt;
      if (wr_bank && wdata < 32'(NBANKS)) bank <= wdata[BW-1:0];
      if (wr_par) bank_mem[bank][addr - 5'd5] <= wdata[PW-1:0];
      if (wr_valid) valid[bank] <= wdata[0];
      if (rd_en) begin
        case (addr)
          5'd0:    rdata <= {22'b0, ie_lock, ie_upd, 3'b0, lock_q, sync_q, 2'b0, go_q};
          5'd1:    rdata <= {28'b0, locked_q, uf_q, 1'b0, vid_active_i};
          5'd2:    rdata <= {22'b0, if_lock, if_upd, 8'b0};
          5'd3:    rdata <= 32'(match_q);
          5'd4:    rdata <= 32'(bank);
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/vmode_regs_chk.sv
module vmode_regs_chk #(
  parameter int NBANKS = 4,
  parameter int BW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [4:0]        addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              underflow_i,
  input logic              locked_i,
  input logic              irq_o,
  input logic              uf_q,
  input logic              locked_q,
  input logic [BW-1:0]     bank,
  input logic [NBANKS-1:0] match_q,
  input logic [1:0]        flags,
  input logic [1:0]        enables
);
  p_bank_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bank) < 32'(NBANKS));
  p_bank_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd4 && wdata >= 32'(NBANKS)) |=> $stable(bank));
  p_match_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_q));
  p_uf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_i |=> uf_q);
  p_uf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !(wr_en && addr == 5'd0 && wdata[2])) |=> uf_q);
  p_lock_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_i && !locked_q) |=> flags[1]);
  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(flags & enables)));
  p_mode_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= 5'd5) |=> rdata == 32'd0);
endmodule

bind vmode_regs vmode_regs_chk #(.NBANKS(NBANKS), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .underflow_i(underflow_i), .locked_i(locked_i),
  .irq_o(irq_o), .uf_q(uf_q), .locked_q(locked_q), .bank(bank), .match_q(match_q),
  .flags({if_lock, if_upd}), .enables({ie_lock, ie_upd})
);

// File: tb/vmode_regs_tb.sv
module vmode_regs_tb_top;
  localparam int CLK_NS = 10;
  localparam int PW = 16;
  localparam int NB = 4;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [PW-1:0] req_mode = 0;
  logic vid_active = 0, underflow = 0, locked = 0;
  logic [31:0] rdata, rdata_off;
  logic go, sync_en, lock_en, irq, irq_off;
  logic go2, sync2, lock2;
  logic [25*PW-1:0] params, params_off;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_d = 0;

  always #(CLK_NS/2) clk = ~clk;

  vmode_regs #(.NBANKS(NB), .PW(PW), .HAS_CTRL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .req_mode_i(req_mode), .vid_active_i(vid_active),
    .underflow_i(underflow), .locked_i(locked), .go_o(go), .sync_en_o(sync_en),
    .lock_en_o(lock_en), .irq_o(irq), .mode_params_o(params));

  vmode_regs #(.NBANKS(NB), .PW(PW), .HAS_CTRL(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_off), .req_mode_i(req_mode), .vid_active_i(vid_active),
    .underflow_i(underflow), .locked_i(locked), .go_o(go2), .sync_en_o(sync2),
    .lock_en_o(lock2), .irq_o(irq_off), .mode_params_o(params_off));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) if (rd_d) begin
    if (exp_q.size() == 0) chk(1, 0, "scoreboard underrun");
    else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    for (int a = 0; a < 5; a++) rd(5'(a), 0, "R1 reset register");
    chk({go, sync_en, lock_en, irq}, 0, "R1 reset outputs");
    chk(32'(params == '0), 1, "R1 reset params");
    // R2 control
    wr(0, 32'h31F); rd(0, 32'h319, "R2 control readback");
    chk({go, sync_en, lock_en}, 3'b111, "R2 outputs all on");
    wr(0, 32'h011); rd(0, 32'h011, "R2 lock bit without sync");
    chk({go, sync_en, lock_en}, 3'b100, "R2 lock gated by sync");
    wr(0, 32'h31F);
    // R3/R4 status and sticky underflow
    vid_active = 1; idle(1); rd(1, 32'h1, "R3 status running");
    @(negedge clk); underflow = 1; @(negedge clk); underflow = 0;
    rd(1, 32'h5, "R4 underflow set"); idle(3); rd(1, 32'h5, "R4 underflow sticky");
    wr(0, 32'h305); rd(1, 32'h1, "R4 underflow cleared");
    rd(0, 32'h301, "R2 clear bit reads 0");
    @(negedge clk); wr_en = 1; addr = 0; wdata = 32'h305; underflow = 1;
    @(negedge clk); wr_en = 0; underflow = 0;
    rd(1, 32'h5, "R4 set wins over clear");
    wr(0, 32'h305); rd(1, 32'h1, "R4 cleared again");
    // R5/R6 lock interrupt
    locked = 1; idle(3);
    rd(1, 32'h9, "R3 locked bit"); rd(2, 32'h200, "R5 lock flag");
    chk(irq, 1, "R6 irq from lock flag"); chk(irq_off, 0, "R6 irq absent without ctrl");
    wr(2, 32'h200); idle(2); rd(2, 32'h0, "R5 lock flag cleared");
    chk(irq, 0, "R6 irq dropped");
    // R8 bank pointer
    wr(4, 2); rd(4, 2, "R8 bank readback");
    wr(4, 7); rd(4, 2, "R8 out of range ignored");
    wr(4, NB); rd(4, 2, "R8 boundary ignored");
    // R9/R7/R10 bank 2 programming
    req_mode = 5;
    wr(6, 32'h780); wr(22, 5);
    rd(3, 0, "R7 no match before valid");
    wr(30, 1); idle(3);
    rd(3, 32'h4, "R7 match bank 2");
    chk(32'(params[1*PW +: PW]), 32'h780, "R10 word 1 of bank 2");
    chk(32'(params[17*PW +: PW]), 5, "R10 standard word");
    rd(6, 0, "R9 mode register reads 0"); rd(30, 0, "R9 valid reads 0");
    rd(2, 32'h100, "R5 update flag on match change");
    chk(irq, 1, "R6 irq from update flag"); chk(irq_off, 0, "R6 irq absent without ctrl");
    // R5 both flags and selective clear
    locked = 0; idle(2); locked = 1; idle(2);
    rd(2, 32'h300, "R5 both flags");
    wr(2, 32'h100); rd(2, 32'h200, "R5 clear one flag only");
    wr(2, 32'h200); idle(2); rd(2, 0, "R5 all clear"); chk(irq, 0, "R6 irq low");
    // R7 lower bank wins
    wr(4, 1); wr(22, 5); wr(30, 1); idle(3);
    rd(3, 32'h2, "R7 lowest bank wins");
    chk(32'(params[17*PW +: PW]), 5, "R10 bank 1 standard");
    chk(32'(params[1*PW +: PW]), 0, "R10 bank 1 word 1 unwritten");
    // R7/R10 no match
    req_mode = 9; idle(3);
    rd(3, 0, "R7 no match gives 0");
    chk(32'(params == '0), 1, "R10 defaults when unmatched");
    // R11 unmapped
    rd(31, 0, "R11 unmapped address");
    idle(3);
    chk(32'(exp_q.size()), 0, "R11 all reads returned");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule